// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block watches one asynchronous infrared receiver line and describes it as a sequence of 8-bit run-length codes. The line is sampled at a prescaled tick rate. With the default divide-by-64 prescaler and an 8 MHz clock, one sample is taken every 8 µs. Each code gives the level of one run in its top bit, where 1 means pulse. The low seven bits give the run's duration as the number of samples minus one.

Before encoding, the line passes through a two-flop synchronizer. An optional inversion follows, then a glitch filter that rejects short disturbances. Encoding starts on the first accepted pulse level after idle. When the line has rested at its inactive level for a programmable number of samples, the block emits the last low run and strobes a packet-end signal. It then stays silent until the next pulse. Codes are pushed downstream one clock at a time. A code offered while the receiver is not ready is lost, and an overflow signal flags the loss.

All configuration inputs are static while the block is enabled. Encoding runs only when the global enable and the receive enable are both high and the mode field holds the infrared-receive value `2'b11`.

Top module: `ir_rle_encoder`

## Requirements
- R1: After reset, `code_valid`, `packet_end` and `overflow` are low.
- R2: Each code carries the run level in bit 7 (1 = pulse, 0 = space). Bits 6:0 hold the run length in samples minus one, so code value n means n+1 samples.
- R3: One sample is taken every `PRESCALE` clocks. A run held for N×`PRESCALE` clocks is reported as N samples.
- R4: With `invert` high, the receiver line is complemented before filtering, so a low line level is a pulse.
- R5: A level change is accepted only after it has been seen on more than `noise_thr` consecutive samples. A disturbance of at most `noise_thr` samples leaves the code stream unchanged.
- R6: Packet end is declared on the `idle_thr`-th consecutive space sample (values below 2 act as 2). On that sample the block emits a space code for the space samples before it, so the field is `idle_thr`−2 when no split occurred. `packet_end` is high for one clock together with that code.
- R7: Space before the first pulse is not encoded. After packet end, no further code appears until the next accepted pulse.
- R8: No code is produced unless `glob_en` and `rx_en` are both high and `mode` equals `2'b11`.
- R9: A run that reaches 128 samples emits a code with bits 6:0 all ones and continues as a new run of the same level. For example, a 300-sample pulse gives 0xFF, 0xFF, 0xAB.
- R10: When `code_valid` is high while `code_ready` is low, the code is dropped and `overflow` is high in that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Asynchronous receiver line |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode, `2'b11` selects infrared receive |
| invert | input | 1 | Complement the line before filtering |
| noise_thr | input | 6 | Glitch filter threshold in samples |
| idle_thr | input | 8 | Idle threshold in samples |
| code_ready | input | 1 | Downstream can take a code this clock |
| code_data | output | 8 | Run-length code |
| code_valid | output | 1 | Code present, one clock per code |
| packet_end | output | 1 | One-clock strobe with the closing space code |
| overflow | output | 1 | Code offered while not ready, dropped |

## Verification
Every line edge reaches the codes late by a fixed amount: two synchronizer clocks, up to one prescaler period, `noise_thr`+1 filter samples, one core sample and one output register. A code therefore lands many clocks after the edge that closes its run. Because every edge is delayed by the same amount, the bench does not compare codes at cycle positions. It drives runs in whole multiples of the sample period and captures each code at the falling clock edge. It then compares the code sequence and packet-end count only after a settling wait of several idle thresholds. `overflow` is the one output due in the same clock as its cause, so it is sampled at the same falling edge as `code_valid`.

// File: rtl/ir_rle_pkg.sv
// Shared constants and types for the infrared run-length encoder.
package ir_rle_pkg;
    localparam logic [1:0] MODE_IR_RX = 2'b11;  // mode value that enables encoding
    localparam int         LEN_W      = 7;      // run length field width
    typedef struct packed {
        logic             pulse;  // run level, 1 = pulse
        logic [LEN_W-1:0] len;    // samples minus one
    } rle_code_t;
endpackage

// File: rtl/ir_rle_sync.sv
// Two-flop synchronizer for the asynchronous line, followed by optional
// inversion. Assumes invert is static while the block is in use.
module ir_rle_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert,
    output logic level
);
    logic meta_q, sync_q;

    // Bring the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
        end
    end

    // Apply the configured polarity.
    always_comb level = sync_q ^ invert;
endmodule

// File: rtl/ir_rle_tick.sv
// Prescaler producing a one-clock sample tick every PRESCALE clocks while
// enabled. Phase restarts when the enable is low. Assumes PRESCALE >= 2.
module ir_rle_tick #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within one sample period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    // Tick on the last clock of each period.
    always_comb tick = en && (cnt_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ir_rle_filter.sv
// Glitch filter: the filtered level follows the raw level only after the
// raw level has differed for more than thr consecutive samples. Cleared to
// the inactive level while disabled. Assumes thr is static while enabled.
module ir_rle_filter #(
    parameter int NOISE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               raw,
    input  logic [NOISE_W-1:0] thr,
    output logic               level
);
    logic [NOISE_W-1:0] diff_q;
    logic [NOISE_W:0]   diff_next;

    always_comb diff_next = {1'b0, diff_q} + 1'b1;

    // Count differing samples and accept the change past the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            level  <= 1'b0;
            diff_q <= '0;
        end else if (tick) begin
            if (raw == level) begin
                diff_q <= '0;
            end else if (diff_next > {1'b0, thr}) begin
                level  <= raw;
                diff_q <= '0;
            end else begin
                diff_q <= diff_next[NOISE_W-1:0];
            end
        end
    end

    // R5
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(level));
endmodule

// File: rtl/ir_rle_core.sv
// Run-length core: measures runs of the filtered level on each tick, splits
// runs at 128 samples, detects idle and emits one registered code per run.
// Assumes idle_thr is static while run_en is high.
module ir_rle_core
    import ir_rle_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              lvl,
    input  logic [IDLE_W-1:0] idle_thr,
    output rle_code_t         code,
    output logic              code_valid,
    output logic              packet_end
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic              busy_q, run_lvl_q;
    logic [LEN_W-1:0]  run_len_q;
    logic [IDLE_W-1:0] idle_q;
    logic [IDLE_W:0]   idle_next;
    logic              idle_hit;

    always_comb begin
        idle_next = {1'b0, idle_q} + 1'b1;
        idle_hit  = idle_next >= {1'b0, idle_thr};
    end

    // Track runs per sample and register the code outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            busy_q     <= 1'b0;
            run_lvl_q  <= 1'b0;
            run_len_q  <= '0;
            idle_q     <= '0;
            code       <= '0;
            code_valid <= 1'b0;
            packet_end <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            packet_end <= 1'b0;
            if (tick) begin
                if (!busy_q) begin
                    if (lvl) begin
                        busy_q    <= 1'b1;
                        run_lvl_q <= 1'b1;
                        run_len_q <= '0;
                        idle_q    <= '0;
                    end
                end else if (lvl != run_lvl_q) begin
                    code       <= '{pulse: run_lvl_q, len: run_len_q};
                    code_valid <= 1'b1;
                    run_lvl_q  <= lvl;
                    run_len_q  <= '0;
                    idle_q     <= lvl ? '0 : IDLE_W'(1);
                end else if (!lvl && idle_hit) begin
                    code       <= '{pulse: 1'b0, len: run_len_q};
                    code_valid <= 1'b1;
                    packet_end <= 1'b1;
                    busy_q     <= 1'b0;
                    run_len_q  <= '0;
                    idle_q     <= '0;
                end else if (run_len_q == LEN_MAX) begin
                    code       <= '{pulse: run_lvl_q, len: LEN_MAX};
                    code_valid <= 1'b1;
                    run_len_q  <= '0;
                    idle_q     <= lvl ? '0 : idle_next[IDLE_W-1:0];
                end else begin
                    run_len_q  <= run_len_q + 1'b1;
                    idle_q     <= lvl ? '0 : idle_next[IDLE_W-1:0];
                end
            end
        end
    end

    // R6
    end_with_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        packet_end |-> (code_valid && !code.pulse));
    // R7
    quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !busy_q) |-> packet_end);
    // R8
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !code_valid);
endmodule

// File: rtl/ir_rle_encoder.sv
// Top level: synchronizer, prescaler, glitch filter and run-length core.
// Codes are offered for one clock; a code offered while code_ready is low
// is lost and flagged on overflow. Configuration inputs must be static
// while the block is enabled.
module ir_rle_encoder
    import ir_rle_pkg::*;
#(
    parameter int PRESCALE = 64,
    parameter int NOISE_W  = 6,
    parameter int IDLE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_in,
    input  logic               glob_en,
    input  logic               rx_en,
    input  logic [1:0]         mode,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               code_ready,
    output logic [7:0]         code_data,
    output logic               code_valid,
    output logic               packet_end,
    output logic               overflow
);
    logic      run_en, sync_lvl, tick, filt_lvl;
    rle_code_t code;

    // Encoding runs only in the receive mode with both enables set.
    always_comb run_en = glob_en && rx_en && (mode == MODE_IR_RX);

    ir_rle_sync u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(ir_in), .invert(invert), .level(sync_lvl)
    );

    ir_rle_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick)
    );

    ir_rle_filter #(.NOISE_W(NOISE_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick),
        .raw(sync_lvl), .thr(noise_thr), .level(filt_lvl)
    );

    ir_rle_core #(.IDLE_W(IDLE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .lvl(filt_lvl),
        .idle_thr(idle_thr), .code(code), .code_valid(code_valid),
        .packet_end(packet_end)
    );

    // Present the code and flag a code that cannot be taken.
    always_comb begin
        code_data = code;
        overflow  = code_valid && !code_ready;
    end
endmodule

// File: tb/test_ir_rle_encoder.sv
module test_ir_rle_encoder;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_in = 1'b0;
    logic       glob_en = 1'b0, rx_en = 1'b0, invert = 1'b0, code_ready = 1'b1;
    logic [1:0] mode = 2'b11;
    logic [5:0] noise_thr = '0;
    logic [7:0] idle_thr = 8'd10;
    logic [7:0] code_data;
    logic       code_valid, packet_end, overflow;

    int errors = 0, checks = 0, cycles = 0;
    logic [7:0] cap [0:15];
    int ncap = 0, npe = 0, nov = 0, ovbad = 0;
    logic [7:0] pe_code = '0;

    always #2 clk = ~clk;

    ir_rle_encoder #(.PRESCALE(P)) i_ir_rle_encoder (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .glob_en(glob_en), .rx_en(rx_en),
        .mode(mode), .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
        .code_ready(code_ready), .code_data(code_data), .code_valid(code_valid),
        .packet_end(packet_end), .overflow(overflow)
    );

    // Capture outputs between clock edges.
    always @(negedge clk) begin
        cycles++;
        if (code_valid) begin
            if (code_ready) begin
                if (ncap < 16) cap[ncap] = code_data;
                ncap++;
            end
            if (packet_end) begin
                npe++;
                pe_code = code_data;
            end
        end
        if (overflow) nov++;
        if (code_valid && !code_ready && !overflow) ovbad++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lv, input int n);
        ir_in = lv ^ invert;
        repeat (n * P) @(negedge clk);
    endtask

    task automatic arm(input bit inv, input int nz, input int idl);
        @(negedge clk);
        glob_en = 1'b0;
        invert = inv;
        noise_thr = 6'(nz);
        idle_thr = 8'(idl);
        ir_in = inv;
        repeat (5) @(negedge clk);
        glob_en = 1'b1;
        rx_en = 1'b1;
        ncap = 0; npe = 0; nov = 0;
    endtask

    task automatic packet(input int nz, input int hi1, input int lo, input int hi2,
                          input int idl, input int gl);
        hold(1'b0, 10);
        hold(1'b1, hi1);
        if (gl > 0) begin
            hold(1'b0, (lo - gl) / 2);
            hold(1'b1, gl);
            hold(1'b0, lo - gl - (lo - gl) / 2);
        end else begin
            hold(1'b0, lo);
        end
        hold(1'b1, hi2);
        hold(1'b0, 3 * idl + nz + 10);
    endtask

    typedef struct packed {
        bit inv; int nz; int hi1; int lo; int hi2; int idl; int gl;
        logic [7:0] e0; logic [7:0] e1; logic [7:0] e2; logic [7:0] e3;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 0, 10, 5, 20, 12, 0, 8'h89, 8'h04, 8'h93, 8'h0A},
        '{1'b1, 2, 6, 9, 3, 20, 2, 8'h85, 8'h08, 8'h82, 8'h12},
        '{1'b0, 5, 40, 30, 7, 40, 4, 8'hA7, 8'h1D, 8'h86, 8'h26},
        '{1'b1, 1, 128, 2, 2, 3, 0, 8'hFF, 8'h01, 8'h81, 8'h01},
        '{1'b0, 0, 1, 1, 1, 2, 0, 8'h80, 8'h00, 8'h80, 8'h00}
    };

    // Watchdog: an expired run counts as a failure and still reports.
    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=done", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!code_valid && !packet_end && !overflow, "R1", {code_valid, packet_end, overflow}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!code_valid && !packet_end && !overflow, "R1", {code_valid, packet_end, overflow}, 0);

        // R2 R3 R4 R5 R6 R7: vector table
        for (int i = 0; i < 5; i++) begin
            arm(VECS[i].inv, VECS[i].nz, VECS[i].idl);
            packet(VECS[i].nz, VECS[i].hi1, VECS[i].lo, VECS[i].hi2, VECS[i].idl, VECS[i].gl);
            check(ncap == 4, "R5/R7 code count", ncap, 4);
            check(cap[0] == VECS[i].e0, "R2/R3/R4 first pulse", cap[0], VECS[i].e0);
            check(cap[1] == VECS[i].e1, "R5 space run", cap[1], VECS[i].e1);
            check(cap[2] == VECS[i].e2, "R2 second pulse", cap[2], VECS[i].e2);
            check(cap[3] == VECS[i].e3, "R6 flush code", cap[3], VECS[i].e3);
            check(npe == 1 && pe_code == VECS[i].e3, "R6 packet end", npe, 1);
        end

        // R9 long pulse split
        arm(1'b0, 0, 10);
        hold(1'b0, 10);
        hold(1'b1, 300);
        hold(1'b0, 40);
        check(ncap == 4, "R9 count", ncap, 4);
        check(cap[0] == 8'hFF && cap[1] == 8'hFF, "R9 split", {cap[0], cap[1]}, 16'hFFFF);
        check(cap[2] == 8'hAB, "R9 remainder", cap[2], 8'hAB);
        check(cap[3] == 8'h08, "R6 after split", cap[3], 8'h08);

        // R8 enable gating
        arm(1'b0, 0, 10);
        mode = 2'b01;
        packet(0, 5, 3, 5, 10, 0);
        check(ncap == 0 && npe == 0, "R8 wrong mode", ncap, 0);
        mode = 2'b11;
        arm(1'b0, 0, 10);
        rx_en = 1'b0;
        packet(0, 5, 3, 5, 10, 0);
        check(ncap == 0, "R8 rx disabled", ncap, 0);
        arm(1'b0, 0, 10);
        glob_en = 1'b0;
        packet(0, 5, 3, 5, 10, 0);
        check(ncap == 0, "R8 global disabled", ncap, 0);

        // R10 overflow when not ready
        arm(1'b0, 0, 10);
        code_ready = 1'b0;
        packet(0, 5, 3, 5, 10, 0);
        check(nov == 4, "R10 overflow count", nov, 4);
        check(ncap == 0 && ovbad == 0, "R10 dropped", ncap, 0);
        code_ready = 1'b1;

        // R7 line held high then idle: single packet, nothing after
        arm(1'b0, 0, 6);
        hold(1'b0, 5);
        hold(1'b1, 4);
        hold(1'b0, 60);
        check(ncap == 2 && cap[0] == 8'h83 && cap[1] == 8'h04, "R7 single packet", ncap, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule